// File: doc/BRIEF.md
# Bit-Sliced Arithmetic, Logic and Shift Unit

This block is a purely combinational datapath unit of parameterised width. It produces one result word from two operand words, a four-bit select word, a carry input and two serial fill bits. Each bit position is assembled from three pieces:

- a slice of an adder whose second operand is chosen as B, the inverse of B, all zeros or all ones;
- a slice of a four-function bitwise unit;
- taps from the neighbouring operand bits for one-place shifts.

A per-bit four-way selector then picks the result. The upper two select bits choose the class of operation. The lower two select bits choose the operation inside that class.

There is no storage, no handshake and no clock. Operands are held steady by the surrounding registers, and the result is taken in the same cycle by whatever register loads it. The carry output only means something for arithmetic codes and reads zero for every other class.

Top module: `alsu_stage_array`

## Requirements
- R1: With sel_i[3:2]=00 (arithmetic), f_o equals (a_i + Y + cin_i) modulo 2^WIDTH. Y is chosen by sel_i[1:0]: 00 gives b_i, 01 gives ~b_i, 10 gives all zeros, 11 gives all ones.
- R2: In the arithmetic class, cout_o is the carry out of the most significant bit position of that sum.
- R3: With sel_i[3:2]=01 (logic), f_o is chosen by sel_i[1:0]: 00 gives a_i AND b_i, 01 gives a_i OR b_i, 10 gives a_i XOR b_i, 11 gives NOT a_i.
- R4: With sel_i[3:2]=10 (shift toward LSB), f_o[i] equals a_i[i+1] for i below WIDTH-1, and f_o[WIDTH-1] equals ser_r_i.
- R5: With sel_i[3:2]=11 (shift toward MSB), f_o[i] equals a_i[i-1] for i above 0, and f_o[0] equals ser_l_i.
- R6: For every select code whose sel_i[3:2] is not 00, cout_o is 0.
- R7: In the two shift classes, b_i, cin_i and sel_i[1:0] have no effect on f_o. In the logic class, cin_i has no effect on f_o.
- R8: ser_r_i affects f_o only in the shift-toward-LSB class. ser_l_i affects f_o only in the shift-toward-MSB class.
- R9: f_o and cout_o depend only on the present inputs, with no clock and no state. The result is valid in the same cycle the inputs are applied.

Ports are listed below in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand; also the source of shifts |
| b_i | input | WIDTH | Second operand |
| sel_i | input | 4 | [3:2] operation class, [1:0] operation within class |
| cin_i | input | 1 | Carry into the least significant adder slice |
| ser_r_i | input | 1 | Fill bit entering the MSB on a shift toward LSB |
| ser_l_i | input | 1 | Fill bit entering the LSB on a shift toward MSB |
| f_o | output | WIDTH | Result word |
| cout_o | output | 1 | Adder carry out; zero outside the arithmetic class |

## Verification
Every result of this block is due zero cycles after its stimulus. Both f_o and cout_o settle from the operands, select word, carry and fill bits alone.

The driver applies each stimulus one time unit after a rising edge and queues the expected word and carry. The monitor pops and compares at the following falling edge, so each comparison falls half a cycle after its stimulus and well before the next one is driven.

All sixteen select codes are exercised with random operands. Directed cases cover carry overflow, equal-operand subtraction, and the fill bits and inputs that should be ignored.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

  // Operation class taken from sel[3:2]
  typedef enum logic [1:0] {
    CLS_ARITH = 2'b00,
    CLS_LOGIC = 2'b01,
    CLS_SHR   = 2'b10,
    CLS_SHL   = 2'b11
  } alsu_class_e;

  // Bitwise function taken from sel[1:0] in the logic class
  typedef enum logic [1:0] {
    LG_AND  = 2'b00,
    LG_OR   = 2'b01,
    LG_XOR  = 2'b10,
    LG_NOTA = 2'b11
  } alsu_logic_e;

  // Adder second-operand source taken from sel[1:0] in the arithmetic class
  typedef enum logic [1:0] {
    OPD_B    = 2'b00,
    OPD_BINV = 2'b01,
    OPD_ZERO = 2'b10,
    OPD_ONES = 2'b11
  } alsu_opd_e;

endpackage

// File: rtl/alsu_arith_bit.sv
module alsu_arith_bit
  import alsu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic [1:0] opd_sel_i,
  input  logic       c_i,
  output logic       d_o,
  output logic       c_o
);

  logic y;

  // Second-operand selector in front of the full adder
  always_comb begin
    unique case (alsu_opd_e'(opd_sel_i))
      OPD_B:    y = b_i;
      OPD_BINV: y = ~b_i;
      OPD_ZERO: y = 1'b0;
      default:  y = 1'b1;
    endcase
  end

  // Full adder slice
  assign d_o = a_i ^ y ^ c_i;
  assign c_o = (a_i & y) | (c_i & (a_i ^ y));

endmodule

// File: rtl/alsu_logic_bit.sv
module alsu_logic_bit
  import alsu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic [1:0] fn_sel_i,
  output logic       e_o
);

  always_comb begin
    unique case (alsu_logic_e'(fn_sel_i))
      LG_AND:  e_o = a_i & b_i;
      LG_OR:   e_o = a_i | b_i;
      LG_XOR:  e_o = a_i ^ b_i;
      default: e_o = ~a_i;
    endcase
  end

endmodule

// File: rtl/alsu_out_mux.sv
module alsu_out_mux
  import alsu_pkg::*;
(
  input  logic [1:0] cls_i,
  input  logic       d_i,
  input  logic       e_i,
  input  logic       shr_tap_i,
  input  logic       shl_tap_i,
  output logic       f_o
);

  always_comb begin
    unique case (alsu_class_e'(cls_i))
      CLS_ARITH: f_o = d_i;
      CLS_LOGIC: f_o = e_i;
      CLS_SHR:   f_o = shr_tap_i;
      default:   f_o = shl_tap_i;
    endcase
  end

endmodule

// File: rtl/alsu_stage_array.sv
module alsu_stage_array
  import alsu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       sel_i,
  input  logic             cin_i,
  input  logic             ser_r_i,
  input  logic             ser_l_i,
  output logic [WIDTH-1:0] f_o,
  output logic             cout_o
);

  localparam int MSB = WIDTH - 1;

  logic [1:0]     cls;
  logic [1:0]     sub;
  logic [WIDTH:0] carry;
  logic [MSB:0]   d_bus;
  logic [MSB:0]   e_bus;
  logic [MSB:0]   shr_tap;
  logic [MSB:0]   shl_tap;

  assign cls      = sel_i[3:2];
  assign sub      = sel_i[1:0];
  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alsu_arith_bit u_arith (
      .a_i       (a_i[i]),
      .b_i       (b_i[i]),
      .opd_sel_i (sub),
      .c_i       (carry[i]),
      .d_o       (d_bus[i]),
      .c_o       (carry[i+1])
    );

    alsu_logic_bit u_logic (
      .a_i      (a_i[i]),
      .b_i      (b_i[i]),
      .fn_sel_i (sub),
      .e_o      (e_bus[i])
    );

    // Neighbour taps for one-place shifts; the ends take the fill bits
    if (i == MSB) begin : g_top_end
      assign shr_tap[i] = ser_r_i;
    end else begin : g_top_mid
      assign shr_tap[i] = a_i[i+1];
    end

    if (i == 0) begin : g_low_end
      assign shl_tap[i] = ser_l_i;
    end else begin : g_low_mid
      assign shl_tap[i] = a_i[i-1];
    end

    alsu_out_mux u_mux (
      .cls_i     (cls),
      .d_i       (d_bus[i]),
      .e_i       (e_bus[i]),
      .shr_tap_i (shr_tap[i]),
      .shl_tap_i (shl_tap[i]),
      .f_o       (f_o[i])
    );
  end

  assign cout_o = (alsu_class_e'(cls) == CLS_ARITH) ? carry[WIDTH] : 1'b0;

  always_comb begin
    if (alsu_class_e'(cls) != CLS_ARITH) begin
      // R6
      cout_quiet_chk: assert (cout_o == 1'b0)
        else $error("carry out not zero outside arithmetic class");
    end
    if (alsu_class_e'(cls) == CLS_SHR) begin
      // R4
      shr_fill_chk: assert (f_o[MSB] == ser_r_i && f_o[MSB-1:0] == a_i[MSB:1])
        else $error("shift toward LSB result wrong");
    end
    if (alsu_class_e'(cls) == CLS_SHL) begin
      // R5
      shl_fill_chk: assert (f_o[0] == ser_l_i && f_o[MSB:1] == a_i[MSB-1:0])
        else $error("shift toward MSB result wrong");
    end
    if (alsu_class_e'(cls) == CLS_ARITH && alsu_opd_e'(sub) == OPD_ZERO && !cin_i) begin
      // R1
      xfer_chk: assert (f_o == a_i && cout_o == 1'b0)
        else $error("zero-operand add did not pass A through");
    end
    if (alsu_class_e'(cls) == CLS_LOGIC && alsu_logic_e'(sub) == LG_XOR) begin
      // R3
      xor_chk: assert (f_o == (a_i ^ b_i))
        else $error("logic XOR result wrong");
    end
  end

endmodule

// File: tb/alsu_stage_array_tb_top.sv
module alsu_stage_array_tb_top;

  localparam int W = 8;

  typedef struct {
    logic [W-1:0] f;
    logic         co;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a, b;
  logic [3:0]   sel;
  logic         cin, sr, sl;
  logic [W-1:0] f;
  logic         co;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;

  alsu_stage_array #(.WIDTH(W)) dut_i (
    .a_i(a), .b_i(b), .sel_i(sel), .cin_i(cin),
    .ser_r_i(sr), .ser_l_i(sl), .f_o(f), .cout_o(co)
  );

  function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                       input logic [3:0] s, input logic c,
                                       input logic r, input logic l);
    logic [W-1:0] opd;
    logic [W:0]   sum;
    case (s[3:2])
      2'b00: begin
        case (s[1:0])
          2'b00: opd = y;
          2'b01: opd = ~y;
          2'b10: opd = '0;
          default: opd = '1;
        endcase
        sum = {1'b0, x} + {1'b0, opd} + {{W{1'b0}}, c};
        return sum;
      end
      2'b01: begin
        case (s[1:0])
          2'b00: return {1'b0, x & y};
          2'b01: return {1'b0, x | y};
          2'b10: return {1'b0, x ^ y};
          default: return {1'b0, ~x};
        endcase
      end
      2'b10: return {1'b0, r, x[W-1:1]};
      default: return {1'b0, x[W-2:0], l};
    endcase
  endfunction

  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input logic [3:0] s,
                       input logic c, input logic r, input logic l, input string tag);
    exp_t e;
    logic [W:0] m;
    @(posedge clk);
    #1;
    a = x; b = y; sel = s; cin = c; sr = r; sl = l;
    m = model(x, y, s, c, r, l);
    e.f = m[W-1:0];
    e.co = m[W];
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare half a cycle after each stimulus
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (f !== e.f || co !== e.co) begin
        n_bad++;
        $display("FAIL %s: sel=%b a=%h b=%h cin=%b got f=%h cout=%b expected f=%h cout=%b",
                 e.tag, sel, a, b, cin, f, co, e.f, e.co);
      end
    end
  end

  initial begin
    a = '0; b = '0; sel = '0; cin = 1'b0; sr = 1'b0; sl = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle inputs: zero-operand add gives zero (R1, R9)
    drive('0, '0, 4'b0000, 1'b0, 1'b0, 1'b0, "R9 idle");
    // Corners for the adder
    drive(8'hFF, 8'h01, 4'b0000, 1'b0, 1'b0, 1'b0, "R2 wrap carry");
    drive(8'h5A, 8'h5A, 4'b0001, 1'b1, 1'b0, 1'b0, "R1 R2 equal subtract");
    drive(8'h03, 8'h05, 4'b0001, 1'b1, 1'b0, 1'b0, "R1 negative difference");
    drive(8'hFF, 8'h00, 4'b0010, 1'b1, 1'b0, 1'b0, "R1 increment wrap");
    drive(8'h00, 8'h00, 4'b0011, 1'b0, 1'b0, 1'b0, "R1 decrement zero");
    // Shift fill bits and ignored inputs
    drive(8'hCE, 8'h00, 4'b1000, 1'b0, 1'b1, 1'b0, "R4 fill one");
    drive(8'hCE, 8'hFF, 4'b1011, 1'b1, 1'b1, 1'b0, "R7 shr ignores b cin sub");
    drive(8'hCE, 8'h00, 4'b1100, 1'b0, 1'b0, 1'b1, "R5 fill one");
    drive(8'hCE, 8'hA5, 4'b1110, 1'b1, 1'b0, 1'b1, "R7 shl ignores b cin sub");
    drive(8'hCE, 8'h00, 4'b1000, 1'b0, 1'b0, 1'b1, "R8 ser_l ignored on shr");
    drive(8'hCE, 8'h00, 4'b1100, 1'b0, 1'b1, 1'b0, "R8 ser_r ignored on shl");
    drive(8'h3C, 8'h0F, 4'b0100, 1'b1, 1'b1, 1'b1, "R7 R8 R6 logic ignores cin fills");
    drive(8'hF0, 8'h00, 4'b0001, 1'b0, 1'b1, 1'b1, "R8 fills ignored in arith");
    // All select codes with random operands (R1 R2 R3 R4 R5 R6)
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 24; k++) begin
        drive(W'($urandom), W'($urandom), 4'(s), 1'($urandom), 1'($urandom), 1'($urandom),
              (s < 4) ? "R1 R2 random arith" : (s < 8) ? "R3 R6 random logic" :
              (s < 12) ? "R4 R6 random shr" : "R5 R6 random shl");
      end
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule